// File: doc/BRIEF.md
# Interpolator Lane Pair with Blend

This block holds the working registers of a two-lane interpolator: two base registers, two accumulators and a small configuration register. A single write port loads any of them. Three combinational read values are always presented: the lane 0 result, the lane 1 result and a full result that combines both lanes.

With blend enabled, lane 1 no longer passes its accumulator through. It returns a linear interpolation between the two bases. The low eight bits of accumulator 1 act as the weight, a fraction in 1/256 steps. The lane 1 signed flag decides whether both bases are treated as two's-complement or unsigned values before the difference is scaled. Lane 0 outside blend is a plain mask-and-extend of accumulator 0, and its own signed flag keeps that role.

A pop strobe presents the same values as a read. At the next edge it also writes each lane's result back into that lane's accumulator, so repeated pops step the interpolator.

Top module: `interp_blend`

## Requirements
- R1: A synchronous reset clears both bases, both accumulators and all configuration bits, so every read output is zero after it.
- R2: A write with `wrEn` high takes effect at the next clock edge. The address selects the target: 0 base 0, 1 base 1, 2 accumulator 0, 3 accumulator 1, 4 configuration. In the configuration word, bit 0 is blend enable, bit 1 is the lane 0 signed flag and bit 2 is the lane 1 signed flag; its other bits are discarded. Addresses 5 to 7 change nothing.
- R3: The lane 0 result is the low 16 bits of accumulator 0. They are sign-extended when the lane 0 signed flag is set and zero-extended when it is clear.
- R4: With blend disabled, the lane 1 result equals accumulator 1.
- R5: With blend enabled, the lane 1 result is base0 + floor((base1 − base0) · alpha / 256), truncated to 32 bits, where alpha = accumulator1[7:0] and the difference is formed on the 33-bit extended bases.
- R6: In blend, the lane 1 signed flag alone picks sign or zero extension of both bases. The lane 0 signed flag has no effect on the lane 1 result.
- R7: With alpha 0 the lane 1 result equals base 0. With alpha 255 it stops one 1/256 step short of base 1. For example, bases −1000 and 1000 in signed mode give 992.
- R8: The full result equals the lane 0 result plus the lane 1 result, modulo 2^32.
- R9: Reading has no side effect. In a cycle with no write and no pop, all outputs keep their values.
- R10: A pop shows the current results. At the next edge it loads each accumulator with its lane's result. A write to an accumulator in the same cycle takes priority over the pop for that accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register select for the write |
| wrData | input | 32 | Write data |
| popEn | input | 1 | Pop strobe: write results back into the accumulators |
| peekLane0 | output | 32 | Lane 0 result |
| peekLane1 | output | 32 | Lane 1 result (blend value when enabled) |
| peekFull | output | 32 | Sum of both lane results |

## Verification
Some properties are checked on every cycle:
- A blend with alpha zero returns base 0.
- In signed blend with ordered bases, the result stays between the two bases.
- Accumulator writes and pops land one edge later.
- The load strobes stay mutually exclusive.
- All outputs hold still when there is neither a write nor a pop.

Other points need the bench's scenarios. These are the exact interpolation values across the alpha sweep in both signedness modes, the one-step shortfall at alpha 255, and the separation of the two signed flags. The bench also covers the mask-and-extend on lane 0, the discarded addresses and configuration bits, and a pop that collides with a write.

// File: rtl/interp_blend_pkg.sv
package interp_blend_pkg;

  localparam int ADDR_W = 3;

  // Register select codes on the write port
  typedef enum logic [ADDR_W-1:0] {
    REG_BASE0 = 3'd0,
    REG_BASE1 = 3'd1,
    REG_ACC0  = 3'd2,
    REG_ACC1  = 3'd3,
    REG_CFG   = 3'd4
  } regSel_e;

  // Bit positions inside the configuration word
  localparam int CFG_BLEND = 0;
  localparam int CFG_SIGN0 = 1;
  localparam int CFG_SIGN1 = 2;
  localparam int CFG_W     = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic ldBase0;
    logic ldBase1;
    logic ldAcc0;
    logic ldAcc1;
    logic ldCfg;
    logic popAcc0;
    logic popAcc1;
  } strobes_t;

endpackage

// File: rtl/interp_ctrl.sv
module interp_ctrl
  import interp_blend_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              popEn,
  output strobes_t          stb
);

  always_comb begin
    stb         = '0;
    stb.ldBase0 = wrEn && (wrAddr == REG_BASE0);
    stb.ldBase1 = wrEn && (wrAddr == REG_BASE1);
    stb.ldAcc0  = wrEn && (wrAddr == REG_ACC0);
    stb.ldAcc1  = wrEn && (wrAddr == REG_ACC1);
    stb.ldCfg   = wrEn && (wrAddr == REG_CFG);
    // A write to an accumulator overrides the pop for that accumulator
    stb.popAcc0 = popEn && !stb.ldAcc0;
    stb.popAcc1 = popEn && !stb.ldAcc1;
  end

  // R2: at most one register is loaded per cycle
  a_r2_single_load: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stb.ldBase0, stb.ldBase1, stb.ldAcc0, stb.ldAcc1, stb.ldCfg}));

  // R10: a colliding write suppresses the pop for that accumulator
  a_r10_write_wins: assert property (@(posedge clk) disable iff (rst)
    (popEn && wrEn && wrAddr == REG_ACC1) |-> !stb.popAcc1);

endmodule

// File: rtl/interp_lerp.sv
module interp_lerp #(
  parameter int DATA_W  = 32,
  parameter int ALPHA_W = 8
) (
  input  logic [DATA_W-1:0]  base0,
  input  logic [DATA_W-1:0]  base1,
  input  logic [ALPHA_W-1:0] alpha,
  input  logic               isSigned,
  output logic [DATA_W-1:0]  lerp
);

  localparam int EXT_W  = DATA_W + 1;
  localparam int PROD_W = EXT_W + ALPHA_W + 1;

  logic signed [PROD_W-1:0] b0x, b1x, diff, alphaX, prod, shifted, sum;
  logic [PROD_W-DATA_W-1:0] unusedSumHi;

  always_comb begin
    b0x     = {{(PROD_W-DATA_W){isSigned & base0[DATA_W-1]}}, base0};
    b1x     = {{(PROD_W-DATA_W){isSigned & base1[DATA_W-1]}}, base1};
    diff    = b1x - b0x;
    alphaX  = {{(PROD_W-ALPHA_W){1'b0}}, alpha};
    prod    = diff * alphaX;
    shifted = prod >>> ALPHA_W;
    sum     = b0x + shifted;
  end

  assign lerp        = sum[DATA_W-1:0];
  assign unusedSumHi = sum[PROD_W-1:DATA_W];

endmodule

// File: rtl/interp_datapath.sv
module interp_datapath
  import interp_blend_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ALPHA_W = 8,
  parameter int LANE0_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  strobes_t          stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] lane0Res,
  output logic [DATA_W-1:0] lane1Res,
  output logic [DATA_W-1:0] fullRes
);

  logic [DATA_W-1:0] base0, base1, acc0, acc1;
  logic              cfgBlend, cfgSign0, cfgSign1;
  logic [DATA_W-1:0] lerpOut;

  always_ff @(posedge clk) begin
    if (rst) begin
      base0    <= '0;
      base1    <= '0;
      acc0     <= '0;
      acc1     <= '0;
      cfgBlend <= 1'b0;
      cfgSign0 <= 1'b0;
      cfgSign1 <= 1'b0;
    end else begin
      if (stb.ldBase0) base0 <= wrData;
      if (stb.ldBase1) base1 <= wrData;
      if (stb.ldAcc0)       acc0 <= wrData;
      else if (stb.popAcc0) acc0 <= lane0Res;
      if (stb.ldAcc1)       acc1 <= wrData;
      else if (stb.popAcc1) acc1 <= lane1Res;
      if (stb.ldCfg) begin
        cfgBlend <= wrData[CFG_BLEND];
        cfgSign0 <= wrData[CFG_SIGN0];
        cfgSign1 <= wrData[CFG_SIGN1];
      end
    end
  end

  // Lane 0: mask to LANE0_W bits, then extend per the lane 0 flag
  generate
    if (LANE0_W < DATA_W) begin : g_lane0Mask
      assign lane0Res = cfgSign0
        ? {{(DATA_W-LANE0_W){acc0[LANE0_W-1]}}, acc0[LANE0_W-1:0]}
        : {{(DATA_W-LANE0_W){1'b0}}, acc0[LANE0_W-1:0]};
    end else begin : g_lane0Full
      assign lane0Res = acc0;
    end
  endgenerate

  interp_lerp #(
    .DATA_W  (DATA_W),
    .ALPHA_W (ALPHA_W)
  ) u_lerp (
    .base0    (base0),
    .base1    (base1),
    .alpha    (acc1[ALPHA_W-1:0]),
    .isSigned (cfgSign1),
    .lerp     (lerpOut)
  );

  assign lane1Res = cfgBlend ? lerpOut : acc1;
  assign fullRes  = lane0Res + lane1Res;

  // R7: zero weight returns base 0 exactly
  a_r7_alpha_zero: assert property (@(posedge clk) disable iff (rst)
    (cfgBlend && acc1[ALPHA_W-1:0] == '0) |-> (lane1Res == base0));

  // R6: signed blend between ordered bases stays inside them
  a_r6_signed_bounds: assert property (@(posedge clk) disable iff (rst)
    (cfgBlend && cfgSign1 && $signed(base0) <= $signed(base1))
      |-> ($signed(lane1Res) >= $signed(base0) && $signed(lane1Res) <= $signed(base1)));

  // R2: accumulator write lands at the next edge
  a_r2_acc0_write: assert property (@(posedge clk) disable iff (rst)
    stb.ldAcc0 |=> (acc0 == $past(wrData)));

  // R10: pop writes the lane 1 result back
  a_r10_pop_acc1: assert property (@(posedge clk) disable iff (rst)
    stb.popAcc1 |=> (acc1 == $past(lane1Res)));

endmodule

// File: rtl/interp_blend.sv
module interp_blend
  import interp_blend_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ALPHA_W = 8,
  parameter int LANE0_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              popEn,
  output logic [DATA_W-1:0] peekLane0,
  output logic [DATA_W-1:0] peekLane1,
  output logic [DATA_W-1:0] peekFull
);

  strobes_t stb;

  interp_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .popEn  (popEn),
    .stb    (stb)
  );

  interp_datapath #(
    .DATA_W  (DATA_W),
    .ALPHA_W (ALPHA_W),
    .LANE0_W (LANE0_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .wrData   (wrData),
    .lane0Res (peekLane0),
    .lane1Res (peekLane1),
    .fullRes  (peekFull)
  );

  // R9: without write or pop, the outputs hold
  a_r9_quiet_hold: assert property (@(posedge clk) disable iff (rst)
    (!wrEn && !popEn) |=> ($stable(peekLane0) && $stable(peekLane1) && $stable(peekFull)));

endmodule

// File: tb/interp_blend_bench.sv
module interp_blend_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        wrEn;
  logic [2:0]  wrAddr;
  logic [31:0] wrData;
  logic        popEn;
  logic [31:0] peekLane0, peekLane1, peekFull;

  always #5 clk = ~clk;

  interp_blend u_interp_blend (
    .clk       (clk),
    .rst       (rst),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .popEn     (popEn),
    .peekLane0 (peekLane0),
    .peekLane1 (peekLane1),
    .peekFull  (peekFull)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    string       tag;
    logic [31:0] l0;
    logic [31:0] l1;
    logic [31:0] fu;
  } exp_t;
  exp_t sbq[$];

  // Reference state built from the requirements
  logic [31:0] mB0, mB1, mA0, mA1;
  bit          mBlend, mS0, mS1;

  function automatic logic [31:0] mLane0();
    return mS0 ? {{16{mA0[15]}}, mA0[15:0]} : {16'h0, mA0[15:0]};
  endfunction

  function automatic logic [31:0] mLane1();
    longint b0, b1, p, r;
    logic [63:0] t;
    if (!mBlend) return mA1;
    b0 = mS1 ? longint'($signed(mB0)) : longint'(mB0);
    b1 = mS1 ? longint'($signed(mB1)) : longint'(mB1);
    p  = (b1 - b0) * longint'(mA1[7:0]);
    r  = b0 + (p >>> 8);
    t  = r;
    return t[31:0];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mB0 = '0; mB1 = '0; mA0 = '0; mA1 = '0;
    mBlend = 0; mS0 = 0; mS1 = 0;
  endtask

  // Driver: applies one cycle of stimulus and queues the expected results
  task automatic drive(input bit w, input logic [2:0] a, input logic [31:0] d,
                       input bit p, input string tag);
    logic [31:0] nl0, nl1;
    exp_t e;
    @(negedge clk);
    wrEn = w; wrAddr = a; wrData = d; popEn = p;
    #1;
    nl0 = mLane0();
    nl1 = mLane1();
    if (p) begin
      check({tag, " pop view lane0"}, peekLane0, nl0);
      check({tag, " pop view lane1"}, peekLane1, nl1);
      mA0 = nl0;
      mA1 = nl1;
    end
    if (w) begin
      case (a)
        3'd0: mB0 = d;
        3'd1: mB1 = d;
        3'd2: mA0 = d;
        3'd3: mA1 = d;
        3'd4: begin mBlend = d[0]; mS0 = d[1]; mS1 = d[2]; end
        default: ;
      endcase
    end
    e.tag = tag;
    e.l0  = mLane0();
    e.l1  = mLane1();
    e.fu  = e.l0 + e.l1;
    sbq.push_back(e);
    @(posedge clk);
    #1;
    wrEn = 0; popEn = 0;
  endtask

  // Monitor: compares outputs after each edge with the queued expectation
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #3;
      if (sbq.size() > 0) begin
        e = sbq.pop_front();
        check({e.tag, " lane0"}, peekLane0, e.l0);
        check({e.tag, " lane1"}, peekLane1, e.l1);
        check({e.tag, " full (R8)"}, peekFull, e.fu);
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL R9 watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin
    logic [31:0] sLit[7];
    logic [31:0] uLit[6];
    int alphas[7];
    alphas = '{0, 42, 85, 127, 170, 212, 255};
    sLit = '{32'hFFFFFC18, 32'hFFFFFD60, 32'hFFFFFEB0, 32'hFFFFFFF8,
             32'h00000148, 32'h00000290, 32'h000003E0};
    uLit = '{32'hFFFFFC18, 32'hD5FFFD60, 32'hAAFFFEB0, 32'h80FFFFF8,
             32'h56000148, 32'h2C000290};

    rst = 1; wrEn = 0; wrAddr = '0; wrData = '0; popEn = 0;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state
    check("R1 reset lane0", peekLane0, 32'h0);
    check("R1 reset lane1", peekLane1, 32'h0);
    check("R1 reset full", peekFull, 32'h0);

    drive(1, 3'd0, 32'hFFFFFC18, 0, "R2 base0 write");
    drive(1, 3'd1, 32'h000003E8, 0, "R2 base1 write");
    drive(1, 3'd4, 32'h5, 0, "R2 cfg blend signed");

    // R5 and R7: signed sweep against known values
    for (int i = 0; i < 7; i++) begin
      drive(1, 3'd3, alphas[i], 0, "R5 signed sweep");
      if (i == 0)      check("R7 alpha zero gives base0", peekLane1, sLit[i]);
      else if (i == 6) check("R7 alpha max one step short", peekLane1, sLit[i]);
      else             check("R5 signed literal", peekLane1, sLit[i]);
    end

    // R6: unsigned treatment of the same bit patterns
    drive(1, 3'd4, 32'h1, 0, "R6 cfg blend unsigned");
    for (int i = 0; i < 6; i++) begin
      drive(1, 3'd3, alphas[i], 0, "R6 unsigned sweep");
      check("R6 unsigned literal", peekLane1, uLit[i]);
    end

    // R6: lane 0 flag has no say over the blend
    drive(1, 3'd3, 32'd42, 0, "R6 alpha 42");
    drive(1, 3'd4, 32'h7, 0, "R6 both flags");
    check("R6 lane0 flag ignored by blend", peekLane1, 32'hFFFFFD60);
    drive(1, 3'd4, 32'h3, 0, "R6 lane0 flag only");
    check("R6 lane0 flag alone is unsigned", peekLane1, 32'hD5FFFD60);

    // R3, R4, R8: non-blend lanes
    drive(1, 3'd4, 32'h0, 0, "R4 cfg plain");
    drive(1, 3'd2, 32'h00018001, 0, "R3 acc0 write");
    check("R3 zero extend", peekLane0, 32'h00008001);
    drive(1, 3'd4, 32'h2, 0, "R3 lane0 signed");
    check("R3 sign extend", peekLane0, 32'hFFFF8001);
    drive(1, 3'd3, 32'h12345678, 0, "R4 acc1 write");
    check("R4 pass through", peekLane1, 32'h12345678);
    check("R8 full sum", peekFull, 32'h1233D679);

    // R2: unused addresses and spare config bits
    drive(1, 3'd5, 32'hDEADBEEF, 0, "R2 address 5 ignored");
    drive(1, 3'd7, 32'hCAFEF00D, 0, "R2 address 7 ignored");
    drive(1, 3'd4, 32'hFFFFFFF8, 0, "R2 spare cfg bits");

    // R9: idle cycles and non-blend pop
    drive(0, 3'd0, 32'h0, 0, "R9 idle");
    drive(0, 3'd3, 32'hFFFFFFFF, 0, "R9 idle with data");
    drive(0, 3'd0, 32'h0, 1, "R10 plain pop");

    // R10: pop in blend mode
    drive(1, 3'd0, 32'hFFFFFC18, 0, "R10 base0");
    drive(1, 3'd1, 32'h000003E8, 0, "R10 base1");
    drive(1, 3'd2, 32'h00000123, 0, "R10 acc0");
    drive(1, 3'd3, 32'd128, 0, "R10 acc1");
    drive(1, 3'd4, 32'h5, 0, "R10 cfg");
    drive(0, 3'd0, 32'h0, 1, "R10 pop one");
    drive(0, 3'd0, 32'h0, 1, "R10 pop two");
    drive(1, 3'd3, 32'd64, 1, "R10 pop with acc1 write");
    drive(1, 3'd2, 32'hFFFF0010, 1, "R10 pop with acc0 write");
    drive(0, 3'd0, 32'h0, 1, "R10 pop three");

    // R1: reset in mid run
    @(negedge clk);
    rst = 1;
    @(posedge clk);
    #1;
    modelReset();
    @(negedge clk);
    rst = 0;
    check("R1 mid reset lane0", peekLane0, 32'h0);
    check("R1 mid reset lane1", peekLane1, 32'h0);
    check("R1 mid reset full", peekFull, 32'h0);

    repeat (3) @(posedge clk);
    #4;
    finishRun();
  end

endmodule